// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block gives a host a two-address window into a bank of configuration registers. The lower address is an index port and the address just above it is a data port. The host first names a register through the index port. It then reads or writes that register through the data port. After reset the window is closed. It opens only when the unlock key byte 0x87 is written to the index port on two index writes in a row. Writing 0xAA to the index port closes it again.

Below index 0x30 lie the global registers. These are a device-number select at 0x07, a read-only identification block and a read-only vendor code. From 0x30 upward, every access goes to the register bank of the device currently selected. Each bank drives its enable bit, its 16-bit base address and a small set of function registers out to the attached function block on dedicated output ports. The bus model is deliberately simple. A read returns combinational data while the access is presented. A write takes effect at the next rising clock edge.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port is at BASE_ADDR and the data port is at BASE_ADDR+1. Reads at any other address return 0xFF, and writes there change nothing.
- R2: From the closed state, writing 0xFF-free key 0x87 to the index port twice in a row opens the window. Any other index byte written between the two keys restarts the sequence. Data-port accesses do not disturb the sequence.
- R3: While the window is open, an index write of 0xAA closes it. Any other index byte, 0x87 included, is stored as the current index.
- R4: While the window is not open, including after a single key, reads at both ports return 0xFF and data-port writes change no register.
- R5: A read of the index port while open returns the last index stored. The index is 0x00 after reset and is kept across a close and reopen.
- R6: Index 0x07 is a read/write 8-bit device number that selects which bank receives accesses at index 0x30 and above.
- R7: Index 0x20 returns DEV_ID[15:8], 0x21 returns DEV_ID[7:0] and 0x22 returns DEV_REV. Writes to these three registers are ignored.
- R8: Index 0x23 returns 0x19 and index 0x24 returns 0x34 (vendor code 0x1934, high byte first). Both registers are read-only.
- R9: In each bank, bit 0 of index 0x30 is the device enable and drives ld_enable[n]. Bits 7:1 of that register read as 0.
- R10: In each bank, index 0x60 holds base bits 15:8 and index 0x61 holds base bits 7:0. The value drives ld_base[16n+15:16n].
- R11: In each bank, index 0xF0+k for k < NUM_FREG is a read/write byte. It drives ld_func[(n*NUM_FREG+k)*8 +: 8].
- R12: Unimplemented indexes read as 0x00 and ignore writes. When the device number is NUM_LD or higher, banked reads return 0x00 and banked writes are dropped.
- R13: After a synchronous active-low reset, the window is closed, the device number is 0 and every bank output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the presented access |
| ld_enable | output | NUM_LD | Per-device enable bits |
| ld_base | output | 16*NUM_LD | Per-device base addresses |
| ld_func | output | 8*NUM_FREG*NUM_LD | Per-device function registers |

## Verification
The bench goes after the unlock sequence. It interleaves a foreign index byte between the keys, and a design that failed to restart the sequence would open on the second key. It also places data-port traffic between the keys, and a design that disturbed the sequence there would stay closed. On relock it checks that the kept index returns after reopening, which a design clearing the index would miss. It writes through the data port while only one key has arrived, and a design that opened early would change a bank output. It selects a device number beyond the last bank, and a design that aliased the number would alter a real bank. A random phase then mixes keys, relock bytes, global, banked and unimplemented indexes against a reference model. This catches wrong byte order in the identification and base registers.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and types for the keyed configuration port.
// Assumes an 8-bit index space and 8-bit data.
package sio_cfg_pkg;
    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    localparam logic [7:0] KEY_OPEN      = 8'h87;
    localparam logic [7:0] KEY_CLOSE     = 8'hAA;
    localparam logic [7:0] LOCKED_READ   = 8'hFF;

    localparam logic [7:0] IX_LDN        = 8'h07;
    localparam logic [7:0] IX_DEVID_HI   = 8'h20;
    localparam logic [7:0] IX_DEVID_LO   = 8'h21;
    localparam logic [7:0] IX_REV        = 8'h22;
    localparam logic [7:0] IX_MFR_HI     = 8'h23;
    localparam logic [7:0] IX_MFR_LO     = 8'h24;
    localparam logic [7:0] IX_BANK_FIRST = 8'h30;
    localparam logic [7:0] IX_ENABLE     = 8'h30;
    localparam logic [7:0] IX_BASE_HI    = 8'h60;
    localparam logic [7:0] IX_BASE_LO    = 8'h61;
    localparam logic [7:0] IX_FUNC_FIRST = 8'hF0;
endpackage

// File: rtl/sio_key_fsm.sv
// Lock state machine for the configuration window.
// Watches index-port writes only. Two consecutive key bytes open the window
// and the close byte shuts it. Assumes idx_wr is a single-cycle strobe per access.
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       store_idx
);
    lock_state_e state_q;
    lock_state_e state_d;

    // Next-state decode from the index byte written this cycle.
    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                LK_CLOSED: state_d = (wdata == KEY_OPEN) ? LK_ARMED : LK_CLOSED;
                LK_ARMED:  state_d = (wdata == KEY_OPEN) ? LK_OPEN  : LK_CLOSED;
                LK_OPEN:   state_d = (wdata == KEY_CLOSE) ? LK_CLOSED : LK_OPEN;
                default:   state_d = LK_CLOSED;
            endcase
        end
    end

    // State register with synchronous reset to the closed state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    assign cfg_open  = (state_q == LK_OPEN);
    assign store_idx = idx_wr && (state_q == LK_OPEN) && (wdata != KEY_CLOSE);

    // R2
    key_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARMED && idx_wr && wdata == KEY_OPEN) |=> cfg_open);

    // R2
    key_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARMED && idx_wr && wdata != KEY_OPEN) |=> (state_q == LK_CLOSED));

    // R2
    open_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> ($past(state_q) == LK_ARMED));

    // R3
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && wdata == KEY_CLOSE) |=> !cfg_open);
endmodule

// File: rtl/sio_global_regs.sv
// Global register area: the index register, the device-number select and
// the read-only identification bytes. Assumes the writes reaching it are
// already qualified by the open window.
module sio_global_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'hA51C,
    parameter logic [7:0]  DEV_REV = 8'h03,
    parameter logic [15:0] MFR_ID  = 16'h1934
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       store_idx,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic [7:0] idx_q,
    output logic [7:0] ldn_q,
    output logic       banked,
    output logic [7:0] glob_rdata
);
    // Index register: holds the last index stored while open.
    always_ff @(posedge clk) begin
        if (!rst_n)         idx_q <= 8'h00;
        else if (store_idx) idx_q <= wdata;
    end

    // Device-number select, written through the data port at its index.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ldn_q <= 8'h00;
        else if (data_wr && idx_q == IX_LDN) ldn_q <= wdata;
    end

    assign banked = (idx_q >= IX_BANK_FIRST);

    // Read decode of the global area; holes read as zero.
    always_comb begin
        case (idx_q)
            IX_LDN:      glob_rdata = ldn_q;
            IX_DEVID_HI: glob_rdata = DEV_ID[15:8];
            IX_DEVID_LO: glob_rdata = DEV_ID[7:0];
            IX_REV:      glob_rdata = DEV_REV;
            IX_MFR_HI:   glob_rdata = MFR_ID[15:8];
            IX_MFR_LO:   glob_rdata = MFR_ID[7:0];
            default:     glob_rdata = 8'h00;
        endcase
    end

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !store_idx |=> $stable(idx_q));

    // R6
    ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && idx_q == IX_LDN) |=> $stable(ldn_q));
endmodule

// File: rtl/sio_ld_bank.sv
// Register bank of one logical device: enable bit, 16-bit base address and
// NUM_FREG function bytes. Assumes wr is already qualified by window,
// banked index and device selection.
module sio_ld_bank
    import sio_cfg_pkg::*;
#(
    parameter int NUM_FREG = 8,
    localparam int FUNC_W  = NUM_FREG * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        idx,
    input  logic [7:0]        wdata,
    output logic              dev_en,
    output logic [15:0]       dev_base,
    output logic [FUNC_W-1:0] dev_func,
    output logic [7:0]        rdata
);
    logic [7:0] func_q [NUM_FREG];
    logic [7:0] func_rd;

    // Enable bit: only bit 0 of the written byte is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dev_en <= 1'b0;
        else if (wr && idx == IX_ENABLE) dev_en <= wdata[0];
    end

    // Base address, high byte at the lower index.
    always_ff @(posedge clk) begin
        if (!rst_n)                           dev_base <= 16'h0000;
        else if (wr && idx == IX_BASE_HI)     dev_base[15:8] <= wdata;
        else if (wr && idx == IX_BASE_LO)     dev_base[7:0]  <= wdata;
    end

    for (genvar k = 0; k < NUM_FREG; k++) begin : g_func
        // Function byte k at its own index above the function window start.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   func_q[k] <= 8'h00;
            else if (wr && idx == IX_FUNC_FIRST + 8'(k))  func_q[k] <= wdata;
        end
        assign dev_func[k*8 +: 8] = func_q[k];
    end

    // Read select over the function bytes.
    always_comb begin
        func_rd = 8'h00;
        for (int k = 0; k < NUM_FREG; k++) begin
            if (idx == IX_FUNC_FIRST + 8'(k)) func_rd = func_q[k];
        end
    end

    // Bank read decode; unimplemented indexes fall through to zero.
    always_comb begin
        case (idx)
            IX_ENABLE:  rdata = {7'b0, dev_en};
            IX_BASE_HI: rdata = dev_base[15:8];
            IX_BASE_LO: rdata = dev_base[7:0];
            default:    rdata = func_rd;
        endcase
    end

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && idx == IX_ENABLE) |=> $stable(dev_en));

    // R10
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (idx == IX_BASE_HI || idx == IX_BASE_LO)) |=> $stable(dev_base));
endmodule

// File: rtl/sio_cfg_port.sv
// Keyed configuration port: index/data port pair at BASE_ADDR and BASE_ADDR+1,
// global register area below 0x30 and one banked register set per logical
// device above it. Reads are combinational while the access is presented.
// Writes land on the next rising edge. Assumes one access per cycle.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4E,
    parameter int                NUM_LD    = 8,
    parameter int                NUM_FREG  = 8,
    parameter logic [15:0]       DEV_ID    = 16'hA51C,
    parameter logic [7:0]        DEV_REV   = 8'h03,
    parameter logic [15:0]       MFR_ID    = 16'h1934,
    localparam int               FUNC_W    = NUM_FREG * 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    output logic [NUM_LD-1:0]        ld_enable,
    output logic [16*NUM_LD-1:0]     ld_base,
    output logic [FUNC_W*NUM_LD-1:0] ld_func
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    logic              hit_idx;
    logic              hit_dat;
    logic              idx_wr;
    logic              data_wr;
    logic              cfg_open;
    logic              store_idx;
    logic [7:0]        idx_q;
    logic [7:0]        ldn_q;
    logic              banked;
    logic [7:0]        glob_rdata;
    logic [NUM_LD-1:0] bank_wr;
    logic [7:0]        bank_rd [NUM_LD];
    logic [7:0]        bank_or;

    assign hit_idx = bus_valid && (bus_addr == BASE_ADDR);
    assign hit_dat = bus_valid && (bus_addr == DATA_ADDR);
    assign idx_wr  = hit_idx && bus_write;
    assign data_wr = hit_dat && bus_write && cfg_open;

    sio_key_fsm u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .wdata     (bus_wdata),
        .cfg_open  (cfg_open),
        .store_idx (store_idx)
    );

    sio_global_regs #(
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV),
        .MFR_ID  (MFR_ID)
    ) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_idx  (store_idx),
        .data_wr    (data_wr),
        .wdata      (bus_wdata),
        .idx_q      (idx_q),
        .ldn_q      (ldn_q),
        .banked     (banked),
        .glob_rdata (glob_rdata)
    );

    for (genvar d = 0; d < NUM_LD; d++) begin : g_bank
        assign bank_wr[d] = data_wr && banked && (ldn_q == 8'(d));

        sio_ld_bank #(.NUM_FREG(NUM_FREG)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (bank_wr[d]),
            .idx      (idx_q),
            .wdata    (bus_wdata),
            .dev_en   (ld_enable[d]),
            .dev_base (ld_base[d*16 +: 16]),
            .dev_func (ld_func[d*FUNC_W +: FUNC_W]),
            .rdata    (bank_rd[d])
        );
    end

    // Route the selected bank's read data; an out-of-range device reads zero.
    always_comb begin
        bank_or = 8'h00;
        for (int d = 0; d < NUM_LD; d++) begin
            if (ldn_q == 8'(d)) bank_or = bank_rd[d];
        end
    end

    // Port read mux: closed window or foreign address reads all ones.
    always_comb begin
        if (!(hit_idx || hit_dat) || !cfg_open) bus_rdata = LOCKED_READ;
        else if (hit_idx)                       bus_rdata = idx_q;
        else if (!banked)                       bus_rdata = glob_rdata;
        else                                    bus_rdata = bank_or;
    end

    // R12
    bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

    // R4
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(ld_enable) && $stable(ld_base) && $stable(ld_func)));

    // R1
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !hit_idx && !hit_dat) |=>
            ($stable(ld_enable) && $stable(ld_base) && $stable(ld_func)));
endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW   = 16;
    localparam logic [15:0] BASE = 16'h004E;
    localparam int          NLD  = 8;
    localparam int          NFR  = 8;
    localparam logic [15:0] DID  = 16'hA51C;
    localparam logic [7:0]  DREV = 8'h03;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [NLD-1:0]    ld_enable;
    logic [16*NLD-1:0] ld_base;
    logic [8*NFR*NLD-1:0] ld_func;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    bit         m_open, m_armed;
    logic [7:0] m_idx, m_ldn;
    logic [NLD-1:0] m_en;
    logic [15:0] m_base [NLD];
    logic [7:0]  m_func [NLD][NFR];

    sio_cfg_port #(
        .ADDR_W(AW), .BASE_ADDR(BASE), .NUM_LD(NLD), .NUM_FREG(NFR),
        .DEV_ID(DID), .DEV_REV(DREV), .MFR_ID(16'h1934)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ld_enable(ld_enable), .ld_base(ld_base), .ld_func(ld_func)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic model_reset();
        m_open = 0; m_armed = 0; m_idx = 8'h00; m_ldn = 8'h00; m_en = '0;
        for (int d = 0; d < NLD; d++) begin
            m_base[d] = 16'h0;
            for (int k = 0; k < NFR; k++) m_func[d][k] = 8'h00;
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] v);
        if (a == BASE) begin
            if (m_open) begin
                if (v == 8'hAA) begin m_open = 0; m_armed = 0; end
                else m_idx = v;
            end else if (v == 8'h87) begin
                if (m_armed) begin m_open = 1; m_armed = 0; end
                else m_armed = 1;
            end else m_armed = 0;
        end else if (a == BASE + 16'd1 && m_open) begin
            if (m_idx == 8'h07) m_ldn = v;
            else if (m_idx >= 8'h30 && m_ldn < NLD) begin
                if (m_idx == 8'h30) m_en[m_ldn] = v[0];
                else if (m_idx == 8'h60) m_base[m_ldn][15:8] = v;
                else if (m_idx == 8'h61) m_base[m_ldn][7:0] = v;
                else if (m_idx >= 8'hF0 && m_idx < 8'hF0 + NFR) m_func[m_ldn][m_idx - 8'hF0] = v;
            end
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (!(a == BASE || a == BASE + 16'd1) || !m_open) return 8'hFF;
        if (a == BASE) return m_idx;
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return DID[15:8];
            8'h21: return DID[7:0];
            8'h22: return DREV;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            default: ;
        endcase
        if (m_idx < 8'h30 || m_ldn >= NLD) return 8'h00;
        if (m_idx == 8'h30) return {7'b0, m_en[m_ldn]};
        if (m_idx == 8'h60) return m_base[m_ldn][15:8];
        if (m_idx == 8'h61) return m_base[m_ldn][7:0];
        if (m_idx >= 8'hF0 && m_idx < 8'hF0 + NFR) return m_func[m_ldn][m_idx - 8'hF0];
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        logic [16*NLD-1:0]    eb;
        logic [8*NFR*NLD-1:0] ef;
        for (int d = 0; d < NLD; d++) begin
            eb[d*16 +: 16] = m_base[d];
            for (int k = 0; k < NFR; k++) ef[(d*NFR + k)*8 +: 8] = m_func[d][k];
        end
        checks++;
        if (ld_enable !== m_en || ld_base !== eb || ld_func !== ef) begin
            errors++;
            $display("FAIL %s: actual en=%0h base=%0h func=%0h expected en=%0h base=%0h func=%0h",
                     tag, ld_enable, ld_base, ld_func, m_en, eb, ef);
        end
    endtask

    // drive at negedge; write lands at the posedge in between
    task automatic wr(input logic [15:0] a, input logic [7:0] v);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        model_write(a, v);
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1;
        chk(tag, {24'h0, bus_rdata}, {24'h0, exp_read(a)});
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] v);
        wr(BASE, ix);
        wr(BASE + 16'd1, v);
    endtask

    task automatic reg_rd(input logic [7:0] ix, input string tag);
        wr(BASE, ix);
        rd(BASE + 16'd1, tag);
    endtask

    task automatic unlock();
        wr(BASE, 8'h87);
        wr(BASE, 8'h87);
    endtask

    function automatic logic [7:0] pick_index();
        int r = $urandom_range(0, 15);
        case (r)
            0, 1: return 8'h87;
            2:    return 8'hAA;
            3:    return 8'h07;
            4:    return 8'h20 + 8'($urandom_range(0, 5));
            5, 6: return 8'h30;
            7:    return 8'h60;
            8:    return 8'h61;
            9, 10, 11: return 8'hF0 + 8'($urandom_range(0, 9));
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R13 reset state
        chk_outs("R13 reset outputs");
        rd(BASE, "R13 index port closed after reset");
        rd(BASE + 16'd1, "R13 data port closed after reset");

        // R4 locked write, then single key
        reg_wr(8'h30, 8'h01);
        chk_outs("R4 locked data write ignored");
        wr(BASE, 8'h87);
        wr(BASE + 16'd1, 8'h5A);
        rd(BASE + 16'd1, "R4 read after one key");
        chk_outs("R4 write after one key ignored");

        // R2 foreign byte between keys restarts sequence
        wr(BASE, 8'h55);
        wr(BASE, 8'h87);
        rd(BASE, "R2 still closed after broken sequence");
        // R2 data access between keys does not disturb
        wr(BASE + 16'd1, 8'h11);
        rd(BASE + 16'd1, "R2 data read between keys");
        wr(BASE, 8'h87);
        rd(BASE, "R2 open after two keys, R5 index reset 0");

        // R7 / R8 identification
        reg_rd(8'h20, "R7 dev id high");
        reg_rd(8'h21, "R7 dev id low");
        reg_rd(8'h22, "R7 revision");
        reg_wr(8'h20, 8'h00);
        rd(BASE + 16'd1, "R7 dev id read-only");
        reg_rd(8'h23, "R8 vendor high");
        reg_rd(8'h24, "R8 vendor low");
        reg_wr(8'h24, 8'hEE);
        rd(BASE + 16'd1, "R8 vendor read-only");

        // R6 device select, R9 enable
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h07, "R6 device number readback");
        reg_wr(8'h30, 8'hFF);
        rd(BASE + 16'd1, "R9 enable reads bit0 only");
        chk_outs("R9 enable output of device 3");

        // R10 base, R11 function bytes
        reg_wr(8'h60, 8'hC3);
        reg_wr(8'h61, 8'h2A);
        reg_rd(8'h60, "R10 base high");
        chk_outs("R10 base output");
        reg_wr(8'hF0, 8'h9E);
        reg_wr(8'hF7, 8'h41);
        reg_rd(8'hF7, "R11 last function byte");
        chk_outs("R11 function outputs");

        // R12 unimplemented and out-of-range device
        reg_wr(8'h31, 8'h77);
        rd(BASE + 16'd1, "R12 unimplemented bank reg");
        reg_wr(8'h25, 8'h77);
        rd(BASE + 16'd1, "R12 unimplemented global reg");
        reg_wr(8'hF8, 8'h77);
        rd(BASE + 16'd1, "R12 beyond function window");
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h60, 8'hBB);
        rd(BASE + 16'd1, "R12 out-of-range device read");
        chk_outs("R12 out-of-range device write dropped");

        // R3 close with 0x87 stored as index while open
        wr(BASE, 8'h87);
        rd(BASE, "R3 key byte stored as index when open");
        wr(BASE, 8'h61);
        wr(BASE, 8'hAA);
        rd(BASE, "R3 closed after close byte");
        rd(BASE + 16'd1, "R3 data closed after close byte");
        unlock();
        rd(BASE, "R5 index kept across reopen");

        // R1 foreign addresses
        wr(BASE + 16'd2, 8'h87);
        wr(BASE - 16'd1, 8'hAA);
        rd(BASE, "R1 foreign writes leave window open");
        rd(BASE + 16'd2, "R1 foreign read");
        rd(16'h002E, "R1 other base read");
        chk_outs("R1 foreign writes no effect");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(0, 9);
            logic [15:0] a;
            case (op)
                0, 1, 2: wr(BASE, pick_index());
                3, 4, 5: begin
                    logic [7:0] v = 8'($urandom);
                    if (m_idx == 8'h07) v = 8'($urandom_range(0, 9));
                    wr(BASE + 16'd1, v);
                end
                6: begin
                    a = BASE + 16'($urandom_range(0, 3)) - 16'd1;
                    wr(a, 8'($urandom));
                end
                default: begin
                    a = BASE + 16'($urandom_range(0, 3)) - 16'd1;
                    rd(a, "R1 R4 R5 R6 R7 R8 R9 R10 R11 R12 random read");
                end
            endcase
            if (n % 16 == 0) chk_outs("R9 R10 R11 random outputs");
            if (n % 500 == 0 && !m_open) unlock();
        end

        // R13 reset mid-run
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        chk_outs("R13 outputs after second reset");
        rd(BASE, "R13 closed after second reset");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule